// File: doc/BRIEF.md
# Page Buffer Cache Controller

This block keeps the tag and state information for a small local cache of whole pages that sits in front of a slow remote memory. One line of the cache holds one 4 KB page, and the line is tagged by its virtual page number. Each request brings a virtual page number, a read/write flag and a keep hint. A hit is answered locally on the next cycle. A miss starts a replacement sequence. First the victim is dealt with: a dirty victim is written back, a clean victim goes to the prefetch buffer if the keep hint is set, and otherwise it is dropped. Then a fetch for the new page is issued. When the remote side reports completion, the page is installed.

Only commands and handshakes are modelled; page data moves elsewhere. The write-back, prefetch-buffer and fetch channels are valid/ready handshakes carrying a page number. Fetch completion is a single-cycle pulse. A separate lookup port lets other logic ask whether a page is resident, without affecting the cache state.

Top module: `page_cache_ctrl`

## Requirements
- R1: The cache is fully associative with ENTRIES lines (default 8), one 4 KB page per line, and each line is tagged by its VPN_W-bit virtual page number.
- R2: An accepted request that hits gives `rsp_valid`=1 with `rsp_hit`=1 in the next cycle. It raises none of `wb_valid`, `pf_valid` or `fetch_valid`, and `remote_busy` stays 0.
- R3: An accepted request that misses raises `fetch_valid` with `fetch_vpn` equal to the requested page, holding both until `fetch_ready`. In the cycle after a `fetch_done` pulse, `rsp_valid`=1 with `rsp_hit`=0, and the page is resident from then on.
- R4: If the victim is dirty, `wb_valid` is raised with `wb_vpn` equal to the victim's page, whatever the keep hint. It is held until `wb_ready`, and `fetch_valid` stays 0 until the write-back has been accepted.
- R5: A clean, valid victim is offered on `pf_valid`/`pf_vpn` when `req_keep`=1, and is dropped with no command when `req_keep`=0.
- R6: The victim is the lowest-indexed invalid line if one exists; otherwise it is the least recently used line. A hit and an install both make the line most recently used.
- R7: A write hit marks the line dirty; a later read hit leaves it dirty. A write miss installs the page already dirty, and a read miss installs it clean.
- R8: Only one miss is in flight at a time. `remote_busy` is 1 from the cycle after a miss is accepted until the response, and `req_ready` is 0 whenever `remote_busy` is 1.
- R9: After reset, every line is invalid, `req_ready`=1, and no command or response is raised.
- R10: `lk_hit` combinationally reports whether `lk_vpn` matches a valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vpn | input | VPN_W | Requested virtual page number |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_keep | input | 1 | Keep hint: a clean victim goes to the prefetch buffer |
| rsp_valid | output | 1 | Request completed (one-cycle pulse) |
| rsp_hit | output | 1 | Completed request was a hit |
| remote_busy | output | 1 | Miss sequence in progress |
| wb_valid | output | 1 | Write-back command valid |
| wb_ready | input | 1 | Write-back command accepted |
| wb_vpn | output | VPN_W | Page to write back |
| pf_valid | output | 1 | Hand-off to the prefetch buffer valid |
| pf_ready | input | 1 | Prefetch buffer accepts |
| pf_vpn | output | VPN_W | Page handed to the prefetch buffer |
| fetch_valid | output | 1 | Remote fetch command valid |
| fetch_ready | input | 1 | Remote fetch command accepted |
| fetch_vpn | output | VPN_W | Page to fetch |
| fetch_done | input | 1 | Remote fetch completed (pulse) |
| lk_vpn | input | VPN_W | Residency query page |
| lk_hit | output | 1 | Queried page is resident |

## Verification
The hardest state to reach is a dirty line that has also become least recently used. To get there, the line must first be made dirty by a write hit, and then every other line must be touched. This has to happen while a write-back is being held off by a stalled `wb_ready`, so that the fetch is shown to wait. The stimulus table fills the cache, dirties pages by both write hits and write misses, and walks the replacement order through clean-keep, clean-drop and dirty victims. It then re-touches all seven other lines so that a write-hit page becomes the victim. A directed miss then holds `wb_ready` low for several cycles.

// File: rtl/pcc_pkg.sv
// Package for the page buffer cache controller: shared types.
// Assumes: included first in compile order.
package pcc_pkg;

    // Miss sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WB    = 3'd1,
        ST_PF    = 3'd2,
        ST_FETCH = 3'd3,
        ST_WAIT  = 3'd4
    } miss_state_t;

endpackage

// File: rtl/pcc_tag_array.sv
// Tag store: valid, dirty and tag per line, with two associative match ports
// (request and residency lookup) and one indexed read port for the victim.
// Assumes: tags of valid lines are unique (only absent pages are installed).
module pcc_tag_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   req_vpn,
    output logic               req_hit,
    output logic [IDX_W-1:0]   req_idx,
    input  logic               set_dirty,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic               sel_valid,
    output logic               sel_dirty,
    output logic [VPN_W-1:0]   sel_tag,
    input  logic               inst_en,
    input  logic [IDX_W-1:0]   inst_idx,
    input  logic [VPN_W-1:0]   inst_tag,
    input  logic               inst_dirty,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] dirty_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] req_match;
    logic [ENTRIES-1:0] lk_match;

    // Per-line comparators for both match ports
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign req_match[g] = valid_q[g] && (tag_q[g] == req_vpn);
        assign lk_match[g]  = valid_q[g] && (tag_q[g] == lk_vpn);
    end

    assign req_hit   = |req_match;
    assign lk_hit    = |lk_match;
    assign valid_vec = valid_q;

    // Encode the matching line index for the request port
    always_comb begin
        req_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (req_match[i]) req_idx = IDX_W'(i);
        end
    end

    // Indexed read of the selected victim line
    assign sel_valid = valid_q[sel_idx];
    assign sel_dirty = dirty_q[sel_idx];
    assign sel_tag   = tag_q[sel_idx];

    // Line state update: install on fetch completion, dirty on write hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
        end else begin
            if (inst_en) begin
                valid_q[inst_idx] <= 1'b1;
                dirty_q[inst_idx] <= inst_dirty;
                tag_q[inst_idx]   <= inst_tag;
            end
            if (set_dirty) dirty_q[req_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/pcc_lru.sv
// Recency ranks (0 = most recent, ENTRIES-1 = least recent) and victim choice.
// Assumes: ranks form a permutation; a touch moves one line to rank 0.
module pcc_lru #(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     touch_en,
    input  logic [IDX_W-1:0]         touch_idx,
    input  logic [ENTRIES-1:0]       valid_vec,
    output logic [IDX_W-1:0]         vic_idx,
    output logic [ENTRIES*IDX_W-1:0] rank_flat
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rank_q [ENTRIES];
    logic [IDX_W-1:0] touched_rank;

    assign touched_rank = rank_q[touch_idx];

    // Flatten ranks for observation
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign rank_flat[g*IDX_W +: IDX_W] = rank_q[g];
    end

    // Rank update: touched line to front, younger lines age by one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)       rank_q[i] <= '0;
                else if (rank_q[i] < touched_rank) rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // Victim choice: lowest invalid line first, else the oldest line
    always_comb begin
        logic found;
        found   = 1'b0;
        vic_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_vec[i]) begin
                vic_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (rank_q[i] == OLDEST) vic_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pcc_miss_fsm.sv
// Miss sequencer: disposes of the victim (write-back, prefetch hand-off or
// drop), then issues the fetch, waits for completion and installs the page.
// Assumes: at most one miss in flight; the caller stalls requests while busy.
module pcc_miss_fsm #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_fire,
    input  logic             req_hit,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_keep,
    input  logic [IDX_W-1:0] vic_idx,
    input  logic             vic_valid,
    input  logic             vic_dirty,
    input  logic [VPN_W-1:0] vic_tag,
    input  logic             wb_ready,
    input  logic             pf_ready,
    input  logic             fetch_ready,
    input  logic             fetch_done,
    output logic             busy,
    output logic             wb_valid,
    output logic [VPN_W-1:0] wb_vpn,
    output logic             pf_valid,
    output logic [VPN_W-1:0] pf_vpn,
    output logic             fetch_valid,
    output logic [VPN_W-1:0] fetch_vpn,
    output logic             install_en,
    output logic [IDX_W-1:0] install_idx,
    output logic [VPN_W-1:0] install_tag,
    output logic             install_dirty,
    output logic             rsp_valid,
    output logic             rsp_hit
);
    import pcc_pkg::*;

    miss_state_t      state_q, state_d;
    logic [VPN_W-1:0] miss_vpn_q;
    logic             miss_wr_q;
    logic [IDX_W-1:0] vic_idx_q;
    logic [VPN_W-1:0] vic_tag_q;
    logic             miss_start;

    assign miss_start = req_fire && !req_hit;

    // Next-state selection for the miss sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (miss_start) begin
                    if (vic_valid && vic_dirty)     state_d = ST_WB;
                    else if (vic_valid && req_keep) state_d = ST_PF;
                    else                            state_d = ST_FETCH;
                end
            end
            ST_WB:    if (wb_ready)    state_d = ST_FETCH;
            ST_PF:    if (pf_ready)    state_d = ST_FETCH;
            ST_FETCH: if (fetch_ready) state_d = ST_WAIT;
            ST_WAIT:  if (fetch_done)  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register and miss context capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            miss_vpn_q <= '0;
            miss_wr_q  <= 1'b0;
            vic_idx_q  <= '0;
            vic_tag_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && miss_start) begin
                miss_vpn_q <= req_vpn;
                miss_wr_q  <= req_write;
                vic_idx_q  <= vic_idx;
                vic_tag_q  <= vic_tag;
            end
        end
    end

    // Response pulse for hits and for completed installs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
        end else begin
            rsp_valid <= (req_fire && req_hit) || install_en;
            rsp_hit   <= req_fire && req_hit;
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign wb_valid      = (state_q == ST_WB);
    assign pf_valid      = (state_q == ST_PF);
    assign fetch_valid   = (state_q == ST_FETCH);
    assign wb_vpn        = vic_tag_q;
    assign pf_vpn        = vic_tag_q;
    assign fetch_vpn     = miss_vpn_q;
    assign install_en    = (state_q == ST_WAIT) && fetch_done;
    assign install_idx   = vic_idx_q;
    assign install_tag   = miss_vpn_q;
    assign install_dirty = miss_wr_q;

endmodule

// File: rtl/page_cache_ctrl.sv
// Page buffer cache controller top: ties the tag store, recency tracker and
// miss sequencer together and presents the request, remote and lookup ports.
// Assumes: page data moves elsewhere; fetch_done pulses once per fetch.
module page_cache_ctrl #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             req_write,
    input  logic             req_keep,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             remote_busy,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [VPN_W-1:0] wb_vpn,
    output logic             pf_valid,
    input  logic             pf_ready,
    output logic [VPN_W-1:0] pf_vpn,
    output logic             fetch_valid,
    input  logic             fetch_ready,
    output logic [VPN_W-1:0] fetch_vpn,
    input  logic             fetch_done,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic                     lookup_hit;
    logic [IDX_W-1:0]         hit_idx;
    logic                     req_fire;
    logic [IDX_W-1:0]         vic_idx;
    logic                     vic_valid;
    logic                     vic_dirty;
    logic [VPN_W-1:0]         vic_tag;
    logic                     install_en;
    logic [IDX_W-1:0]         install_idx;
    logic [VPN_W-1:0]         install_tag;
    logic                     install_dirty;
    logic [ENTRIES-1:0]       valid_vec;
    logic [ENTRIES*IDX_W-1:0] rank_flat;
    logic                     touch_en;
    logic [IDX_W-1:0]         touch_idx;

    assign req_ready = !remote_busy;
    assign req_fire  = req_valid && req_ready;
    assign touch_en  = (req_fire && lookup_hit) || install_en;
    assign touch_idx = install_en ? install_idx : hit_idx;

    pcc_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vpn    (req_vpn),
        .req_hit    (lookup_hit),
        .req_idx    (hit_idx),
        .set_dirty  (req_fire && lookup_hit && req_write),
        .lk_vpn     (lk_vpn),
        .lk_hit     (lk_hit),
        .sel_idx    (vic_idx),
        .sel_valid  (vic_valid),
        .sel_dirty  (vic_dirty),
        .sel_tag    (vic_tag),
        .inst_en    (install_en),
        .inst_idx   (install_idx),
        .inst_tag   (install_tag),
        .inst_dirty (install_dirty),
        .valid_vec  (valid_vec)
    );

    pcc_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .valid_vec (valid_vec),
        .vic_idx   (vic_idx),
        .rank_flat (rank_flat)
    );

    pcc_miss_fsm #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_fire      (req_fire),
        .req_hit       (lookup_hit),
        .req_vpn       (req_vpn),
        .req_write     (req_write),
        .req_keep      (req_keep),
        .vic_idx       (vic_idx),
        .vic_valid     (vic_valid),
        .vic_dirty     (vic_dirty),
        .vic_tag       (vic_tag),
        .wb_ready      (wb_ready),
        .pf_ready      (pf_ready),
        .fetch_ready   (fetch_ready),
        .fetch_done    (fetch_done),
        .busy          (remote_busy),
        .wb_valid      (wb_valid),
        .wb_vpn        (wb_vpn),
        .pf_valid      (pf_valid),
        .pf_vpn        (pf_vpn),
        .fetch_valid   (fetch_valid),
        .fetch_vpn     (fetch_vpn),
        .install_en    (install_en),
        .install_idx   (install_idx),
        .install_tag   (install_tag),
        .install_dirty (install_dirty),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit)
    );

endmodule

// File: rtl/pcc_checker.sv
// Protocol and state checker for page_cache_ctrl, attached by bind.
// Assumes: observes ports plus the lookup result and the recency ranks.
module pcc_checker #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     req_hit,
    input logic                     remote_busy,
    input logic                     rsp_valid,
    input logic                     rsp_hit,
    input logic                     wb_valid,
    input logic                     wb_ready,
    input logic [VPN_W-1:0]         wb_vpn,
    input logic                     pf_valid,
    input logic                     pf_ready,
    input logic [VPN_W-1:0]         pf_vpn,
    input logic                     fetch_valid,
    input logic                     fetch_ready,
    input logic [VPN_W-1:0]         fetch_vpn,
    input logic [ENTRIES*IDX_W-1:0] rank_flat
);

    logic [ENTRIES-1:0] rank_seen;

    // Collect which rank values are present
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < ENTRIES; i++) rank_seen[rank_flat[i*IDX_W +: IDX_W]] = 1'b1;
    end

    AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_hit) |=> (rsp_valid && rsp_hit && !remote_busy)); // R2
    AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_hit) |=> (remote_busy && !rsp_valid)); // R3
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_vpn))); // R3
    AST_BUSY_END_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(remote_busy) |-> (rsp_valid && !rsp_hit)); // R3
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_vpn))); // R4
    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, pf_valid, fetch_valid})); // R4
    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_vpn))); // R5
    AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_seen == {ENTRIES{1'b1}})); // R6
    AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        remote_busy |-> !req_ready); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!remote_busy && !wb_valid && !pf_valid && !fetch_valid && !rsp_valid)); // R9

endmodule

bind page_cache_ctrl pcc_checker #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_hit     (lookup_hit),
    .remote_busy (remote_busy),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_vpn      (wb_vpn),
    .pf_valid    (pf_valid),
    .pf_ready    (pf_ready),
    .pf_vpn      (pf_vpn),
    .fetch_valid (fetch_valid),
    .fetch_ready (fetch_ready),
    .fetch_vpn   (fetch_vpn),
    .rank_flat   (rank_flat)
);

// File: tb/page_cache_ctrl_tb.sv
// Bench for page_cache_ctrl: a table of requests with expected hit and
// victim outcomes, then directed reset, back-pressure and lookup tests.
module page_cache_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int VPN_W      = 20;
    localparam int NROWS      = 36;
    localparam int WATCHDOG   = 20000;

    // Row: vpn[20:13] write[12] keep[11] exp_hit[10] exp_wb[9] exp_pf[8] exp_victim[7:0]
    localparam logic [20:0] VEC [NROWS] = '{
        {8'd1,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd2,  1'b1,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd3,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd4,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd5,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd6,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd7,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd8,  1'b0,1'b0,1'b0,1'b0,1'b0,8'd0},
        {8'd1,  1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd3,  1'b1,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd9,  1'b0,1'b0,1'b0,1'b1,1'b0,8'd2},
        {8'd10, 1'b0,1'b1,1'b0,1'b0,1'b1,8'd4},
        {8'd11, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd5},
        {8'd6,  1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd12, 1'b0,1'b1,1'b0,1'b0,1'b1,8'd7},
        {8'd2,  1'b0,1'b1,1'b0,1'b0,1'b1,8'd8},
        {8'd3,  1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd13, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd1},
        {8'd14, 1'b1,1'b1,1'b0,1'b0,1'b1,8'd9},
        {8'd14, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd15, 1'b0,1'b1,1'b0,1'b0,1'b1,8'd10},
        {8'd16, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd11},
        {8'd17, 1'b0,1'b1,1'b0,1'b0,1'b1,8'd6},
        {8'd18, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd12},
        {8'd19, 1'b0,1'b1,1'b0,1'b0,1'b1,8'd2},
        {8'd20, 1'b0,1'b1,1'b0,1'b1,1'b0,8'd3},
        {8'd21, 1'b0,1'b0,1'b0,1'b0,1'b0,8'd13},
        {8'd22, 1'b0,1'b1,1'b0,1'b1,1'b0,8'd14},
        {8'd15, 1'b1,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd16, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd17, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd18, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd19, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd20, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd21, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0},
        {8'd22, 1'b0,1'b0,1'b1,1'b0,1'b0,8'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [VPN_W-1:0] req_vpn = '0;
    logic             req_write = 1'b0;
    logic             req_keep = 1'b0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic             remote_busy;
    logic             wb_valid;
    logic             wb_ready = 1'b1;
    logic [VPN_W-1:0] wb_vpn;
    logic             pf_valid;
    logic             pf_ready = 1'b1;
    logic [VPN_W-1:0] pf_vpn;
    logic             fetch_valid;
    logic             fetch_ready = 1'b1;
    logic [VPN_W-1:0] fetch_vpn;
    logic             fetch_done = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             lk_hit;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    page_cache_ctrl #(.ENTRIES(8), .VPN_W(VPN_W)) u_dut (.*);

    // Clock generator
    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Record one check and report a mismatch
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one request, play the remote side, and check the outcome
    task automatic run_req(input int vpn, input bit wr, input bit keep, input bit ehit,
                           input bit ewb, input bit epf, input int evic, input int bp);
        bit saw_wb = 0, saw_pf = 0, saw_fetch = 0, stall_bad = 0, order_bad = 0, done = 0;
        int wbv = -1, pfv = -1, fv = -1, fd_cnt = 0, bp_left = bp;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_vpn = VPN_W'(vpn); req_write = wr; req_keep = keep;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 80 && !done; c++) begin
            fetch_done = 1'b0;
            if (rsp_valid) begin
                done = 1;
            end else begin
                if (remote_busy && req_ready) stall_bad = 1;
                if (wb_valid) begin
                    if (saw_wb && wbv != int'(wb_vpn)) order_bad = 1;
                    saw_wb = 1; wbv = int'(wb_vpn);
                    if (bp_left > 0) begin wb_ready = 1'b0; bp_left--; end
                    else wb_ready = 1'b1;
                end
                if (pf_valid) begin saw_pf = 1; pfv = int'(pf_vpn); end
                if (fetch_valid) begin
                    if (ewb && !saw_wb) order_bad = 1;
                    if (bp_left > 0) order_bad = 1;
                    saw_fetch = 1; fv = int'(fetch_vpn); fd_cnt = 3;
                end else if (fd_cnt > 0) begin
                    fd_cnt--;
                    if (fd_cnt == 0) fetch_done = 1'b1;
                end
                @(negedge clk);
            end
        end
        fetch_done = 1'b0; wb_ready = 1'b1;
        chk(done == 1, "R3 response arrives", done, 1);
        chk(rsp_hit == ehit, ehit ? "R2 hit response" : "R3 miss response", rsp_hit, ehit);
        if (ehit) chk(!(saw_wb || saw_pf || saw_fetch), "R2 no remote traffic on hit",
                      saw_wb || saw_pf || saw_fetch, 0);
        else chk(saw_fetch && fv == vpn, "R3 fetch page", fv, vpn);
        chk(saw_wb == ewb, "R4 write-back issued", saw_wb, ewb);
        if (ewb) chk(wbv == evic, "R4 write-back page (R7 dirty state)", wbv, evic);
        chk(saw_pf == epf, "R5 prefetch hand-off issued", saw_pf, epf);
        if (epf) chk(pfv == evic, "R5 prefetch page (R6 victim)", pfv, evic);
        chk(!order_bad, "R4 write-back before fetch", order_bad, 0);
        chk(!stall_bad, "R8 stall while busy", stall_bad, 0);
        lk_vpn = VPN_W'(vpn);
        #1;
        chk(lk_hit == 1'b1, "R10 page resident after request", lk_hit, 1);
    endtask

    // Query residency through the lookup port
    task automatic check_lookup(input int vpn, input bit exp, input string req);
        @(negedge clk);
        lk_vpn = VPN_W'(vpn);
        #1;
        chk(lk_hit == exp, req, lk_hit, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
        chk(!(wb_valid || pf_valid || fetch_valid || rsp_valid || remote_busy),
            "R9 quiet after reset", wb_valid || pf_valid || fetch_valid, 0);
        lk_vpn = '0;
        #1;
        chk(lk_hit == 1'b0, "R9 R10 no page resident after reset", lk_hit, 0);
        rst_n = 1'b1;

        // R1 R6 R7: table walk through fill, hits and LRU replacement
        for (int i = 0; i < NROWS; i++) begin
            run_req(int'(VEC[i][20:13]), VEC[i][12], VEC[i][11], VEC[i][10],
                    VEC[i][9], VEC[i][8], int'(VEC[i][7:0]), 0);
        end

        // R1 R10: evicted pages are gone, others remain
        check_lookup(14, 1'b0, "R10 evicted page absent");
        check_lookup(2, 1'b0, "R10 evicted page absent");
        check_lookup(15, 1'b1, "R10 resident page present");

        // R4: dirty LRU victim with write-back held off for 3 cycles
        run_req(30, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 15, 3);
        check_lookup(15, 1'b0, "R4 written-back page absent");

        // R7: write miss installs dirty; evict it next as LRU after touching others
        run_req(31, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16, 0);
        for (int v = 17; v <= 22; v++) run_req(v, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
        run_req(30, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
        run_req(32, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 31, 0);

        // R9: reset mid-state clears residency
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_lookup(32, 1'b0, "R9 reset clears lines");
        run_req(32, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule